// File: doc/BRIEF.md
# I/O Address Trap Monitor

This block watches the processor's I/O cycles and raises a system-management interrupt (SMI) when an access lands in one of four programmable trap windows. Each monitor holds a 16-bit base address that can point anywhere in the 64 KB I/O space. A 4-bit mask can exclude any of the low four address bits from the compare, so a single monitor can cover an aligned group of up to sixteen ports.

A cycle can trap only if three conditions hold at once: the monitor's trap enable is set, the address matches under the mask, and some target positively decodes the cycle. A trap sets a sticky per-monitor status bit. The SMI output stays high while any status bit is set together with its enable.

A cycle aimed at an internal register completes as usual. A trapped cycle aimed at LPC is passed on only when the forwarding enable is set. Cycles that trap nowhere pass to LPC whenever they target it. Software programs the block through a small word-indexed register port with byte enables.

Top module: `iotrap_top`

## Requirements
- R1: After reset, every base register, the mask register and the status register read zero, and `smi` is low.
- R2: Writes go to the register chosen by `reg_idx`, which is 0..3 for the monitor bases, 4 for the mask and 5 for the status. `reg_be[0]` gates bits 7:0 and `reg_be[1]` gates bits 15:8, and a lane whose enable is clear keeps its old value. Reads on `reg_rdata` are combinational and show current contents.
- R3: When a mask bit is 1, the same address bit (3:0) is left out of the compare and every other bit must equal the base. For example, base 0x1230 with mask 0011b matches 0x1230 to 0x1233 and not 0x1234.
- R4: Monitor n uses mask bits 4n+3:4n, so bits 3:0 go to monitor 0 and bits 15:12 go to monitor 3.
- R5: Status bit n (read at index 5, bit n) sets on the clock edge that ends a cycle where `cyc_valid`, `cyc_decoded` and `trap_en[n]` are all high and the address matches monitor n. With any of these missing, nothing sets.
- R6: Status bits are sticky. Writing 1 with the low byte enabled clears a bit, and writing 0 or leaving the lane disabled has no effect. A new trap in the same cycle as a clear keeps the bit set.
- R7: `smi` is high exactly while some status bit and its trap enable are both set. It falls when those bits are cleared or their enables drop.
- R8: A trapped cycle with `cyc_lpc` high drives `lpc_fwd` only when `fwd_en` is high.
- R9: A valid LPC cycle that traps no enabled monitor always drives `lpc_fwd`. A cycle with `cyc_lpc` low never does.
- R10: One cycle may trap several monitors, and every one of them latches status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_be | input | 2 | Byte lane enables |
| reg_rdata | output | 16 | Read data for `reg_idx` |
| cyc_valid | input | 1 | I/O cycle present |
| cyc_addr | input | 16 | I/O cycle address |
| cyc_decoded | input | 1 | Cycle positively decoded by some target |
| cyc_lpc | input | 1 | Cycle target is LPC |
| trap_en | input | 4 | Per-monitor trap enables |
| fwd_en | input | 1 | Permit forwarding of trapped LPC cycles |
| smi | output | 1 | System-management interrupt request |
| lpc_fwd | output | 1 | Forward current cycle to LPC |

## Verification
Addresses are placed at the inside and outside edges of a masked window (0x1233 against 0x1234), which shows that masked bits are ignored while unmasked bits still count. The same matching address is then sent with decode low and with its enable low, which separates each gating term from the address compare. LPC cycles are run trapped and untrapped with forwarding on and off, which shows that the forward decision depends on the trap. Overlapping windows and a monitor-3 window check that each monitor takes its own mask nibble and that several monitors can trap at once. A clear and a trap landing in the same cycle confirm that the set wins.

// File: rtl/iotrap_pkg.sv
package iotrap_pkg;
    localparam int DEF_NMON = 4;
    localparam int DEF_AW   = 16;
    localparam int DEF_MW   = 4;

    function automatic logic window_hit(
        input logic [DEF_AW-1:0] base,
        input logic [DEF_AW-1:0] addr,
        input logic [DEF_MW-1:0] dont_care
    );
        logic [DEF_AW-1:0] care;
        care = {{(DEF_AW-DEF_MW){1'b1}}, ~dont_care};
        return ((base ^ addr) & care) == '0;
    endfunction
endpackage

// File: rtl/iotrap_regs.sv
module iotrap_regs #(
    parameter int NMON = 4,
    parameter int AW   = 16,
    parameter int MW   = 4,
    parameter int IW   = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr,
    input  logic [IW-1:0]            idx,
    input  logic [AW-1:0]            wdata,
    input  logic [AW/8-1:0]          be,
    input  logic [NMON-1:0]          set_vec,
    output logic [AW-1:0]            rdata,
    output logic [NMON-1:0][AW-1:0]  bases,
    output logic [NMON*MW-1:0]       mask,
    output logic [NMON-1:0]          status
);
    localparam int NB      = AW / 8;
    localparam int MKW     = NMON * MW;
    localparam int MASKIDX = NMON;
    localparam int STATIDX = NMON + 1;

    logic [AW-1:0]   lane;
    logic [NMON-1:0] clr_vec;

    always_comb begin
        for (int b = 0; b < NB; b++) lane[b*8 +: 8] = {8{be[b]}};
    end

    assign clr_vec = (wr && idx == IW'(STATIDX)) ? (wdata[NMON-1:0] & lane[NMON-1:0]) : '0;

    for (genvar i = 0; i < NMON; i++) begin : g_base
        always_ff @(posedge clk) begin
            if (rst)                         bases[i] <= '0;
            else if (wr && idx == IW'(i))    bases[i] <= (bases[i] & ~lane) | (wdata & lane);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask   <= '0;
            status <= '0;
        end else begin
            if (wr && idx == IW'(MASKIDX))
                mask <= (mask & ~lane[MKW-1:0]) | (wdata[MKW-1:0] & lane[MKW-1:0]);
            status <= (status & ~clr_vec) | set_vec;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NMON; i++)
            if (idx == IW'(i)) rdata = bases[i];
        if (idx == IW'(MASKIDX)) rdata = AW'(mask);
        if (idx == IW'(STATIDX)) rdata = AW'(status);
    end
endmodule

// File: rtl/iotrap_match.sv
module iotrap_match #(
    parameter int NMON = 4,
    parameter int AW   = 16,
    parameter int MW   = 4
) (
    input  logic [NMON-1:0][AW-1:0] bases,
    input  logic [NMON*MW-1:0]      mask,
    input  logic [AW-1:0]           addr,
    output logic [NMON-1:0]         hit
);
    import iotrap_pkg::*;
    for (genvar i = 0; i < NMON; i++) begin : g_cmp
        assign hit[i] = window_hit(bases[i], addr, mask[i*MW +: MW]);
    end
endmodule

// File: rtl/iotrap_decide.sv
module iotrap_decide #(
    parameter int NMON = 4
) (
    input  logic            cyc_valid,
    input  logic            cyc_decoded,
    input  logic            cyc_lpc,
    input  logic [NMON-1:0] hit,
    input  logic [NMON-1:0] trap_en,
    input  logic            fwd_en,
    input  logic [NMON-1:0] status,
    output logic [NMON-1:0] set_vec,
    output logic            smi,
    output logic            lpc_fwd
);
    logic claimed;
    assign claimed = cyc_valid && cyc_decoded;
    assign set_vec = claimed ? (hit & trap_en) : '0;
    assign smi     = |(status & trap_en);
    assign lpc_fwd = cyc_valid && cyc_lpc && (!(|set_vec) || fwd_en);
endmodule

// File: rtl/iotrap_top.sv
module iotrap_top #(
    parameter int NMON = 4,
    parameter int AW   = 16,
    parameter int MW   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_wr,
    input  logic [$clog2(NMON+2)-1:0]    reg_idx,
    input  logic [AW-1:0]                reg_wdata,
    input  logic [AW/8-1:0]              reg_be,
    output logic [AW-1:0]                reg_rdata,
    input  logic                         cyc_valid,
    input  logic [AW-1:0]                cyc_addr,
    input  logic                         cyc_decoded,
    input  logic                         cyc_lpc,
    input  logic [NMON-1:0]              trap_en,
    input  logic                         fwd_en,
    output logic                         smi,
    output logic                         lpc_fwd
);
    localparam int IW = $clog2(NMON + 2);

    logic [NMON-1:0][AW-1:0] bases;
    logic [NMON*MW-1:0]      mask_q;
    logic [NMON-1:0]         status_q;
    logic [NMON-1:0]         hit_vec;
    logic [NMON-1:0]         set_vec;

    iotrap_regs #(.NMON(NMON), .AW(AW), .MW(MW), .IW(IW)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
        .be(reg_be), .set_vec(set_vec), .rdata(reg_rdata), .bases(bases),
        .mask(mask_q), .status(status_q)
    );

    iotrap_match #(.NMON(NMON), .AW(AW), .MW(MW)) u_match (
        .bases(bases), .mask(mask_q), .addr(cyc_addr), .hit(hit_vec)
    );

    iotrap_decide #(.NMON(NMON)) u_decide (
        .cyc_valid(cyc_valid), .cyc_decoded(cyc_decoded), .cyc_lpc(cyc_lpc),
        .hit(hit_vec), .trap_en(trap_en), .fwd_en(fwd_en), .status(status_q),
        .set_vec(set_vec), .smi(smi), .lpc_fwd(lpc_fwd)
    );
endmodule

// File: rtl/iotrap_chk.sv
module iotrap_chk #(
    parameter int NMON = 4,
    parameter int IW   = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            cyc_valid,
    input logic            cyc_decoded,
    input logic            cyc_lpc,
    input logic            fwd_en,
    input logic            reg_wr,
    input logic [IW-1:0]   reg_idx,
    input logic [NMON-1:0] hit,
    input logic [NMON-1:0] trap_en,
    input logic [NMON-1:0] status,
    input logic            lpc_fwd
);
    logic [NMON-1:0] armed;
    logic            clearing;
    assign armed    = hit & trap_en;
    assign clearing = reg_wr && reg_idx == IW'(NMON + 1);

    AST_TRAP_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_decoded && (|armed)) |=> ((status & $past(armed)) == $past(armed))); // R5
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        (!(cyc_valid && cyc_decoded) || armed == '0) |=> ((status & ~$past(status)) == '0)); // R5
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clearing |=> ((status & $past(status)) == $past(status))); // R6
    AST_TRAPPED_LPC_HELD: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_decoded && cyc_lpc && (|armed) && !fwd_en) |-> !lpc_fwd); // R8
    AST_LPC_PASSES: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_lpc && (armed == '0 || fwd_en)) |-> lpc_fwd); // R9
    AST_NON_LPC_STAYS: assert property (@(posedge clk) disable iff (rst)
        !(cyc_valid && cyc_lpc) |-> !lpc_fwd); // R9
endmodule

bind iotrap_top iotrap_chk #(.NMON(NMON), .IW(IW)) u_chk (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_decoded(cyc_decoded),
    .cyc_lpc(cyc_lpc), .fwd_en(fwd_en), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .hit(hit_vec), .trap_en(trap_en), .status(status_q), .lpc_fwd(lpc_fwd)
);

// File: tb/sim_iotrap_top.sv
module sim_iotrap_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [15:0] reg_wdata = '0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_rdata;
    logic        cyc_valid = 1'b0;
    logic [15:0] cyc_addr = '0;
    logic        cyc_decoded = 1'b0;
    logic        cyc_lpc = 1'b0;
    logic [3:0]  trap_en = '0;
    logic        fwd_en = 1'b0;
    logic        smi;
    logic        lpc_fwd;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       req;
    } item_t;
    item_t sb[$];
    event  chk_ev;

    always #10 clk = ~clk;

    iotrap_top u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
        .reg_be(reg_be), .reg_rdata(reg_rdata), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .cyc_decoded(cyc_decoded), .cyc_lpc(cyc_lpc), .trap_en(trap_en), .fwd_en(fwd_en),
        .smi(smi), .lpc_fwd(lpc_fwd)
    );

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = sb.pop_front();
                act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? {15'b0, smi} : {15'b0, lpc_fwd};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input int k, input logic [15:0] e, input string r);
        sb.push_back('{k, e, r});
        -> chk_ev;
        #2;
    endtask

    task automatic rd(input int idx, input logic [15:0] e, input string r);
        @(negedge clk);
        reg_idx = 3'(idx);
        expect_item(0, e, r);
    endtask

    task automatic wr(input int idx, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 3'(idx); reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic cyc(input logic [15:0] a, input logic dec, input logic lpc,
                       input logic efwd, input string r);
        @(negedge clk);
        cyc_valid = 1'b1; cyc_addr = a; cyc_decoded = dec; cyc_lpc = lpc;
        expect_item(2, {15'b0, efwd}, r);
        @(negedge clk);
        cyc_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        for (int i = 0; i < 6; i++) rd(i, 16'h0000, "R1");
        expect_item(1, 16'h0, "R1");
        // R2 byte-enabled writes and readback
        wr(0, 16'h1230, 2'b11); rd(0, 16'h1230, "R2");
        wr(1, 16'hAB55, 2'b10); rd(1, 16'hAB00, "R2");
        wr(1, 16'h0080, 2'b11); rd(1, 16'h0080, "R2");
        wr(4, 16'h00F3, 2'b01); rd(4, 16'h00F3, "R4");
        wr(4, 16'hFFFF, 2'b00); rd(4, 16'h00F3, "R2");
        // R3 masked window edges, R5 latch
        trap_en = 4'b0001;
        cyc(16'h1233, 1'b1, 1'b0, 1'b0, "R3");
        rd(5, 16'h0001, "R5");
        expect_item(1, 16'h1, "R7");
        wr(5, 16'h0001, 2'b11); rd(5, 16'h0000, "R6");
        expect_item(1, 16'h0, "R7");
        cyc(16'h1234, 1'b1, 1'b0, 1'b0, "R3"); rd(5, 16'h0000, "R3");
        cyc(16'h1230, 1'b0, 1'b0, 1'b0, "R5"); rd(5, 16'h0000, "R5");
        trap_en = 4'b0000;
        cyc(16'h1231, 1'b1, 1'b1, 1'b1, "R9"); rd(5, 16'h0000, "R5");
        // R8 trapped LPC cycle held back; R4 nibble of monitor 1
        trap_en = 4'b0011;
        cyc(16'h008F, 1'b1, 1'b1, 1'b0, "R8"); rd(5, 16'h0002, "R4");
        expect_item(1, 16'h1, "R7");
        wr(5, 16'h0002, 2'b10); rd(5, 16'h0002, "R6");
        @(negedge clk) trap_en = 4'b0001; expect_item(1, 16'h0, "R7");
        @(negedge clk) trap_en = 4'b0011; expect_item(1, 16'h1, "R7");
        wr(5, 16'h0001, 2'b11); rd(5, 16'h0002, "R6");
        fwd_en = 1'b1;
        cyc(16'h0085, 1'b1, 1'b1, 1'b1, "R8");
        cyc(16'h0090, 1'b1, 1'b1, 1'b1, "R9");
        cyc(16'h1230, 1'b1, 1'b0, 1'b0, "R9"); rd(5, 16'h0003, "R5");
        wr(5, 16'h000F, 2'b11); rd(5, 16'h0000, "R6");
        expect_item(1, 16'h0, "R7");
        // R6 set wins over clear in the same cycle
        cyc(16'h0081, 1'b1, 1'b0, 1'b0, "R9"); rd(5, 16'h0002, "R5");
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 3'd5; reg_wdata = 16'h0002; reg_be = 2'b11;
        cyc_valid = 1'b1; cyc_addr = 16'h0088; cyc_decoded = 1'b1; cyc_lpc = 1'b0;
        @(negedge clk);
        reg_wr = 1'b0; cyc_valid = 1'b0;
        rd(5, 16'h0002, "R6");
        wr(5, 16'h000F, 2'b11);
        // R10 overlapping monitors, R4 top nibble
        wr(2, 16'h0084, 2'b11);
        wr(3, 16'h1000, 2'b11);
        wr(4, 16'hF0F3, 2'b10); rd(4, 16'hF0F3, "R4");
        trap_en = 4'b1111;
        cyc(16'h0084, 1'b1, 1'b0, 1'b0, "R10"); rd(5, 16'h0006, "R10");
        wr(5, 16'h000F, 2'b11);
        cyc(16'h100A, 1'b1, 1'b0, 1'b0, "R4"); rd(5, 16'h0008, "R4");
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule